// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous, single-master request port and an external asynchronous static RAM. The RAM has 16-bit words and a 16-bit address. Each request carries an address, write data, a read/write flag and a two-bit byte strobe, and is accepted with a valid/ready handshake. The controller then runs one complete memory cycle on the active-low chip-select, write-strobe, output-enable and per-byte lane-select pins. Each of the memory's minimum AC timings is held as a clock-cycle count parameter.

Writes are ended by the write strobe. Address, lanes and data are placed one cycle before the strobe falls. The strobe rises first while chip-select stays low, so the address and data hold times are met. Reads keep the outputs enabled for the access window, capture the bus and return the word with a one-cycle valid pulse. After every read, a turnaround gap covers the memory's float delay before the controller may drive the bus again. The data pins are presented pad-side as a split output, output-enable and input, so the tri-state buffer lives in the pad ring.

Top module: `sram_ctrl`

## Requirements
- R1: While idle, chip-select, write strobe and output enable are all high, the data drivers are off, and `req_ready_o` is high. `req_ready_o` is high only while idle, so it is low in the cycle after a request is accepted.
- R2: Strobe bit 0 selects the lower lane (data bits 7:0, `sram_lb_no`) and bit 1 the upper lane (bits 15:8, `sram_ub_no`). A lane select is driven low only while chip-select is low and its strobe bit is set, so a request with strobe 00 touches no memory location.
- R3: For a write, address, lane selects and data are presented with chip-select low for one cycle before the write strobe falls, and all three stay unchanged while the strobe is low.
- R4: The write strobe stays low for max(WE_LOW_CYC, ADDR_WE_CYC-1, DATA_SETUP_CYC-1) cycles. With the defaults and a 10 ns clock this gives at least 40 ns of strobe low, 60 ns of address and lane setup, and 30 ns of data setup before the strobe rises.
- R5: A write is ended by the write strobe rising while chip-select is still low. Address and data are then held for at least one more cycle, and the address never changes while the strobe is low.
- R6: Output enable is high throughout every write cycle.
- R7: Chip-select stays low for at least WR_CYCLE_CYC cycles per write (70 ns by default).
- R8: A read holds chip-select, output enable and the strobed lanes low, with the write strobe high, for max(RD_ACC_CYC, OE_ACC_CYC) cycles. The bus is captured on the edge that ends this window, at least 70 ns after address and output enable become valid.
- R9: Read data appears with `rsp_valid_o` high for exactly one cycle. The bits of lanes not strobed read as zero.
- R10: The data drivers are enabled only in write states, never while output enable is low. After output enable rises at the end of a read, they stay off for at least TURN_CYC cycles.
- R11: A byte-masked write changes only its strobed lane. A later read of each lane returns the most recent data written to that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and able to accept |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_be_i | input | DATA_W/8 | Byte strobe, bit 0 = bits 7:0 |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W | Read data, unstrobed lanes zero |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data toward the memory |
| sram_dq_oe_o | output | 1 | Enable for the data pad drivers |
| sram_dq_i | input | DATA_W | Data from the memory pads |
| sram_ce_no | output | 1 | Chip-select, active low |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_ub_no | output | 1 | Upper lane select, active low |
| sram_lb_no | output | 1 | Lower lane select, active low |

## Verification
Cycle-level properties are checked on every clock. These cover the idle deselect and ready relation, output enable staying high while the write strobe is low, and drivers never overlapping output enable. They also cover stable address, data and lanes under the strobe, chip-select low when the strobe rises, the minimum strobe width and turnaround gap counted in cycles, and the single-cycle response. Only the bench's scenarios can show the nanosecond AC limits, as seen by a behavioural memory model that drives corrupted data until the access time has elapsed and keeps driving through its float window. The same scenarios also show byte-masked merging, per-lane read-back, the strobe-00 no-op and back-to-back read/write turnaround.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctrl_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              sel_i,
  input  logic [LANES-1:0]  be_i,
  output logic [LANES-1:0]  lane_n_o,
  output logic [DATA_W-1:0] mask_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n_o[g]              = ~(sel_i & be_i[g]);
    assign mask_o[g*LANE_W +: LANE_W] = {LANE_W{be_i[g]}};
  end

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // address and data held for the whole memory cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i & mask_i;
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned WE_LOW_CYC     = 4,
  parameter int unsigned ADDR_WE_CYC    = 6,
  parameter int unsigned DATA_SETUP_CYC = 3,
  parameter int unsigned WR_CYCLE_CYC   = 7,
  parameter int unsigned RD_ACC_CYC     = 7,
  parameter int unsigned OE_ACC_CYC     = 4,
  parameter int unsigned TURN_CYC       = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [ADDR_W-1:0]   sram_addr_o,
  output logic [DATA_W-1:0]   sram_dq_o,
  output logic                sram_dq_oe_o,
  input  logic [DATA_W-1:0]   sram_dq_i,
  output logic                sram_ce_no,
  output logic                sram_we_no,
  output logic                sram_oe_no,
  output logic                sram_ub_no,
  output logic                sram_lb_no
);

  localparam int unsigned LANES     = DATA_W / 8;
  // setup cycle already covers one cycle of address and data setup
  localparam int unsigned PULSE_CYC = max_u(WE_LOW_CYC,
                                      max_u(ADDR_WE_CYC - 1, DATA_SETUP_CYC - 1));
  localparam int unsigned REC_CYC   = (WR_CYCLE_CYC > PULSE_CYC + 2) ?
                                      (WR_CYCLE_CYC - 1 - PULSE_CYC) : 1;
  localparam int unsigned RD_WAIT   = max_u(RD_ACC_CYC, OE_ACC_CYC);
  localparam int unsigned TURN_EFF  = max_u(TURN_CYC, 1);
  localparam int unsigned TMR_MAX   = max_u(max_u(PULSE_CYC, REC_CYC),
                                      max_u(RD_WAIT, TURN_EFF));
  localparam int unsigned CNT_W     = $clog2(TMR_MAX + 1);

  ctrl_state_e      state_q, state_d;
  logic [LANES-1:0] be_q;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             cyc_sel;
  logic             rd_phase;
  logic             wr_phase;
  logic             capture;
  logic [LANES-1:0] lane_n;
  logic [DATA_W-1:0] lane_mask;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     be_q <= '0;
    else if (accept) be_q <= req_be_i;
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_we_i) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d  = ST_RD_ACCESS;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_WAIT - 1);
          end
        end
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PULSE_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          state_d  = ST_WR_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WR_RECOVER: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      ST_RD_ACCESS: begin
        if (tmr_done) state_d = ST_RD_CAPTURE;
      end
      ST_RD_CAPTURE: begin
        state_d  = ST_TURNAROUND;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TURN_EFF - 1);
      end
      ST_TURNAROUND: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign rd_phase = (state_q == ST_RD_ACCESS);
  assign wr_phase = (state_q == ST_WR_SETUP) | (state_q == ST_WR_PULSE) |
                    (state_q == ST_WR_RECOVER);
  assign cyc_sel  = rd_phase | wr_phase;
  assign capture  = rd_phase & tmr_done;

  sram_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_lane_decode #(
    .LANES  (LANES),
    .LANE_W (8)
  ) u_lanes (
    .sel_i    (cyc_sel),
    .be_i     (be_q),
    .lane_n_o (lane_n),
    .mask_o   (lane_mask)
  );

  sram_dq_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .capture_i (capture),
    .mask_i    (lane_mask),
    .dq_i      (sram_dq_i),
    .addr_o    (sram_addr_o),
    .wdata_o   (sram_dq_o),
    .rdata_o   (rsp_rdata_o)
  );

  assign sram_ce_no   = ~cyc_sel;
  assign sram_we_no   = (state_q != ST_WR_PULSE);
  assign sram_oe_no   = ~rd_phase;
  assign sram_dq_oe_o = wr_phase;
  assign sram_lb_no   = lane_n[0];
  assign sram_ub_no   = lane_n[LANES-1];
  assign rsp_valid_o  = (state_q == ST_RD_CAPTURE);

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned WE_LOW_CYC = 4,
  parameter int unsigned TURN_CYC   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic              sram_ub_no,
  input logic              sram_lb_no
);

  logic [7:0] we_low_cnt;
  logic [7:0] oe_gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              we_low_cnt <= '0;
    else if (sram_we_no)      we_low_cnt <= '0;
    else if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               oe_gap_cnt <= '1;
    else if (!sram_oe_no)      oe_gap_cnt <= '0;
    else if (oe_gap_cnt != '1) oe_gap_cnt <= oe_gap_cnt + 1'b1;
  end

  a_r1_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));

  a_r2_lanes_off_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_no |-> (sram_ub_no && sram_lb_no));

  a_r3_stable_under_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> ($stable(sram_dq_o) && $stable(sram_ub_no) &&
                     $stable(sram_lb_no) && sram_dq_oe_o));

  a_r4_strobe_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_low_cnt >= WE_LOW_CYC));

  a_r5_addr_hold_strobe_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> $stable(sram_addr_o));

  a_r5_ce_low_at_strobe_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> !sram_ce_no);

  a_r6_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no);

  a_r9_rsp_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r10_no_drive_with_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  a_r10_turnaround_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (oe_gap_cnt >= TURN_CYC));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .WE_LOW_CYC (WE_LOW_CYC),
  .TURN_CYC   (TURN_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_ub_no   (sram_ub_no),
  .sram_lb_no   (sram_lb_no)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam longint T_WLWH  = 40;
  localparam longint T_AVWH  = 60;
  localparam longint T_DVWH  = 30;
  localparam longint T_BLWH  = 60;
  localparam longint T_WC    = 70;
  localparam longint T_AA    = 70;
  localparam longint T_FLOAT = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, sram_addr, sram_dq_o, sram_dq_i;
  logic        sram_dq_oe, ce_n, we_n, oe_n, ub_n, lb_n;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] shadow [int unsigned];
  logic [15:0] mem    [int unsigned];

  logic        m_drive = 1'b0;
  logic [15:0] m_dq = '0;
  assign sram_dq_i = m_drive ? m_dq : 16'h0000;

  always #(HALF) clk = ~clk;

  sram_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe),
    .sram_dq_i(sram_dq_i), .sram_ce_no(ce_n), .sram_we_no(we_n),
    .sram_oe_no(oe_n), .sram_ub_no(ub_n), .sram_lb_no(lb_n)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // behavioural memory: checks AC minimums, corrupts early reads, floats late
  longint t_addr = 0, t_data = 0, t_lane = 0, t_ce = 0, t_wef = 0, t_rd = 0;
  longint t_off = -1000;
  logic p_we = 1'b1, p_ce = 1'b1, p_rd = 1'b0, p_dqoe = 1'b0, p_wrote = 1'b0;
  logic [15:0] p_addr = '0, p_dq = '0;
  logic [1:0]  p_lanes = 2'b11;

  always @(negedge clk) begin : model
    longint now, rf;
    logic rd_en;
    logic [15:0] word, wm;
    now = $time;
    if (rst_n) begin
      rd_en = !ce_n && we_n && !oe_n && !(ub_n && lb_n);
      if (sram_addr != p_addr) begin
        if (!we_n) check(1'b0, "R5 address moved under strobe", sram_addr, p_addr);
        t_addr = now;
      end
      if (sram_dq_oe && (!p_dqoe || sram_dq_o != p_dq)) t_data = now;
      if ({ub_n, lb_n} != p_lanes) t_lane = now;
      if (!ce_n && p_ce) t_ce = now;
      if (ce_n && !p_ce && p_wrote) begin
        check(now - t_ce >= T_WC, "R7 write cycle span", now - t_ce, T_WC);
        p_wrote = 1'b0;
      end
      if (!we_n && p_we) begin
        t_wef = now;
        check(oe_n, "R6 oe high at strobe fall", oe_n, 1);
      end
      if (we_n && !p_we) begin
        check(now - t_wef  >= T_WLWH, "R4 strobe low width", now - t_wef, T_WLWH);
        check(now - t_addr >= T_AVWH, "R4 address setup", now - t_addr, T_AVWH);
        check(now - t_data >= T_DVWH, "R4 data setup", now - t_data, T_DVWH);
        check(now - t_lane >= T_BLWH, "R4 lane setup", now - t_lane, T_BLWH);
        check(!ce_n, "R5 ce low at strobe rise", ce_n, 0);
        wm   = {{8{!ub_n}}, {8{!lb_n}}};
        word = mem.exists(sram_addr) ? mem[sram_addr] : 16'h0000;
        mem[sram_addr] = (word & ~wm) | (sram_dq_o & wm);
        p_wrote = 1'b1;
      end
      if (sram_dq_oe && !p_dqoe)
        check(!m_drive, "R10 driver overlaps memory drive", m_drive, 0);
      if (rd_en && !p_rd) t_rd = now;
      if (!rd_en && p_rd) t_off = now - HALF;
      if (rd_en) begin
        rf   = (t_addr > t_rd) ? t_addr : t_rd;
        word = mem.exists(sram_addr) ? mem[sram_addr] : 16'h0000;
        m_dq = ((now + HALF) - (rf - HALF) >= T_AA) ? word : ~word;
        m_drive = 1'b1;
      end else begin
        m_drive = (now < t_off + T_FLOAT);
      end
      p_rd = rd_en;
    end
    p_we = we_n; p_ce = ce_n; p_dqoe = sram_dq_oe; p_addr = sram_addr;
    p_dq = sram_dq_o; p_lanes = {ub_n, lb_n};
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_rdata, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata == e, "R8/R9/R11 read data", rsp_rdata, e);
      end
    end
  end

  task automatic issue(input logic we, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    logic [15:0] old, m;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    m   = lane_mask(be);
    old = shadow.exists(a) ? shadow[a] : 16'h0000;
    if (we) shadow[a] = (old & ~m) | (d & m);
    else    exp_q.push_back(old & m);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1 ready low while busy", req_ready, 0);
  endtask

  logic done = 1'b0;
  int   cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);
    check(ce_n && we_n && oe_n, "R1 controls high after reset", {ce_n, we_n, oe_n}, 7);
    check(!sram_dq_oe && !rsp_valid, "R1 drivers off after reset", sram_dq_oe, 0);
    check(ub_n && lb_n, "R2 lanes idle", {ub_n, lb_n}, 3);

    // full-word writes and reads at edge addresses
    issue(1'b1, 16'h0000, 16'hA5C3, 2'b11);
    issue(1'b1, 16'hFFFF, 16'h1234, 2'b11);
    issue(1'b0, 16'h0000, 16'h0, 2'b11);
    issue(1'b0, 16'hFFFF, 16'h0, 2'b11);
    // R11 lower lane only, upper preserved
    issue(1'b1, 16'h0000, 16'hFF77, 2'b01);
    issue(1'b0, 16'h0000, 16'h0, 2'b11);
    // R11 upper lane only, read each lane separately (R9 zero fill)
    issue(1'b1, 16'hFFFF, 16'h9900, 2'b10);
    issue(1'b0, 16'hFFFF, 16'h0, 2'b01);
    issue(1'b0, 16'hFFFF, 16'h0, 2'b10);
    // R2 strobe 00 write touches nothing, read returns zero
    issue(1'b1, 16'h0000, 16'h0BAD, 2'b00);
    issue(1'b0, 16'h0000, 16'h0, 2'b00);
    issue(1'b0, 16'h0000, 16'h0, 2'b11);
    // R10 read directly followed by write then read
    issue(1'b0, 16'h0000, 16'h0, 2'b11);
    issue(1'b1, 16'h0000, 16'h4242, 2'b11);
    issue(1'b0, 16'h0000, 16'h0, 2'b11);

    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      issue(lfsr[0], 16'h3000 | {13'h0, lfsr[3:1]}, lfsr ^ 16'h5A5A, lfsr[5:4]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    check(ce_n && sram_dq_oe == 1'b0, "R1 idle at end", ce_n, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule